// File: doc/BRIEF.md
# Subclock Interval Tick and Divided-Clock Output

This block runs entirely on the 32.768 kHz subsystem clock. A free-running 12-bit prescaler counts every subclock cycle. Two features are taken from its bits. The first is a periodic interval tick whose period is chosen from seven powers of two. The second is a divided clock pin that can be switched on or off and runs at one of two rates.

A single 8-bit control byte configures both features. It is written and read through a plain synchronous port in the same clock domain. Turning the tick on clears the prescaler, so the first tick after enabling arrives exactly one full period later. Both outputs share the prescaler. For that reason, the first divided-clock period after a prescaler clear may come out shorter than the programmed one.

Top module: `subclk_timer`

## Requirements
- R1: After reset the control byte reads 0x00, and both `tick_o` and `div_o` are low.
- R2: Control bit 7 enables the tick, bit 6 enables the divided output, bit 5 selects the divided rate, and bits 2:0 hold the interval code. Bits 4:3 always read as zero. All other bits read back as written.
- R3: While bit 7 is 0, `tick_o` stays low for every interval code.
- R4: For codes 0 to 5 the tick period is 2^(6+code) subclock cycles. The first tick comes 2^(6+code) cycles after the write that sets bit 7, because that write clears the prescaler.
- R5: Codes 6 and 7 both give a period of 4096 cycles.
- R6: Each tick is high for exactly one subclock cycle.
- R7: A write made while bit 7 is already 1 leaves the interval code unchanged.
- R8: With bit 6 at 1 and bit 5 at 0, `div_o` is a square wave with a 64-cycle period: 32 cycles high, then 32 cycles low.
- R9: With bits 6 and 5 both at 1, `div_o` inverts on every subclock cycle.
- R10: When bit 6 is 0, `div_o` goes low within two cycles and then stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subsystem clock, 32.768 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes `wr_data` into the control byte on this edge |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Current control byte |
| tick_o | output | 1 | Interval tick, one cycle wide |
| div_o | output | 1 | Divided clock output |

## Verification
The bench builds the block with its default parameters: a 12-bit prescaler, a shortest interval of 2^6 cycles, and the slow divided rate taken from prescaler bit 5. With these values every interval code can be reached, up to and including the two codes that clamp to 4096 cycles. Both the first tick after enabling and the steady period are measured for each code. The default widths also put the full slow divided-clock period and the two-cycle stop window within a short run.

// File: rtl/subclk_timer.sv
module subclk_timer #(
  parameter int PRE_W     = 12,
  parameter int BASE_LOG  = 6,
  parameter int SEL_W     = 3,
  parameter int SLOW_TAP  = 5,
  parameter int FAST_TAP  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       tick_o,
  output logic       div_o
);
  localparam int MAX_CODE = PRE_W - BASE_LOG;

  logic             ie, oen, fsel;
  logic [SEL_W-1:0] sel;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;
  logic             tick_q, div_q;
  logic             ie_rise;

  assign ie_rise = wr_en && wr_data[7] && !ie;
  assign rd_data = {ie, oen, fsel, 2'b00, sel};
  assign tick_o  = tick_q;
  assign div_o   = div_q;

  always_comb begin
    int n;
    n = BASE_LOG + ((int'(sel) > MAX_CODE) ? MAX_CODE : int'(sel));
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < n) mask[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      oen  <= 1'b0;
      fsel <= 1'b0;
      sel  <= '0;
    end else if (wr_en) begin
      ie   <= wr_data[7];
      oen  <= wr_data[6];
      fsel <= wr_data[5];
      if (!ie) sel <= wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (ie_rise) pre <= '0;
    else              pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      div_q  <= 1'b0;
    end else begin
      tick_q <= ie && !ie_rise && ((pre & mask) == mask);
      div_q  <= oen && (fsel ? pre[FAST_TAP] : pre[SLOW_TAP]);
    end
  end
endmodule

// File: rtl/subclk_timer_chk.sv
module subclk_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       tick_o,
  input logic       div_o
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:3] == 2'b00);

  assert_no_tick_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_data[7]) |-> !tick_o);

  assert_tick_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  assert_code_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_data[7]) |-> $stable(rd_data[2:0]));

  assert_div_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_data[6]) |-> !div_o);
endmodule

bind subclk_timer subclk_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .tick_o(tick_o), .div_o(div_o)
);

// File: tb/tb_subclk_timer.sv
module tb_subclk_timer;
  localparam int CLK_PERIOD = 30;
  localparam int PER [8] = '{64, 128, 256, 512, 1024, 2048, 4096, 4096};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick_o, div_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  subclk_timer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o && n < 10000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h00, "R1 ctrl", rd_data, 0);
    check(!tick_o && !div_o, "R1 outputs", {tick_o, div_o}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      write(8'(i));
      write(8'h80 | 8'(i));
      wait_tick(n);
      check(n == PER[i], (i >= 6) ? "R5 first" : "R4 first", n, PER[i]);
      wait_tick(n);
      check(n == PER[i], (i >= 6) ? "R5 period" : "R4 period", n, PER[i]);
      @(negedge clk);
      check(!tick_o, "R6 width", tick_o, 0);
      write(8'h00);
    end

    write(8'h7F);
    check(rd_data == 8'h67, "R2 readback", rd_data, 8'h67);
    write(8'h07);
    n = 0;
    for (int i = 0; i < 5000; i++) begin @(negedge clk); if (tick_o) n++; end
    check(n == 0, "R3 disabled", n, 0);

    write(8'h00);
    write(8'h80);
    write(8'h85);
    check(rd_data[2:0] == 3'd0, "R7 code kept", rd_data[2:0], 0);
    wait_tick(n);
    wait_tick(n);
    check(n == 64, "R7 period", n, 64);
    write(8'h00);

    write(8'h40);
    n = 0;
    while (div_o && n < 200) begin @(negedge clk); n++; end
    while (!div_o && n < 400) begin @(negedge clk); n++; end
    n = 0;
    while (div_o && n < 200) begin @(negedge clk); n++; end
    check(n == 32, "R8 high", n, 32);
    n = 0;
    while (!div_o && n < 200) begin @(negedge clk); n++; end
    check(n == 32, "R8 low", n, 32);

    write(8'h60);
    @(negedge clk);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      logic prev;
      prev = div_o;
      @(negedge clk);
      if (div_o == prev) n++;
    end
    check(n == 0, "R9 toggle", n, 0);

    write(8'h20);
    @(negedge clk);
    check(!div_o, "R10 stop", div_o, 0);
    n = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (div_o) n++; end
    check(n == 0, "R10 parked", n, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule